// File: doc/BRIEF.md
# Multichannel Compare-Based PWM Timer

This block is a bank of independent pulse-width channels sharing one clock and one register port. Every channel owns a 16-bit up-counter, a duty compare value, a period compare value and a three-bit control word. While a channel runs, its counter steps by one on each cycle where that channel's tick-enable input is high. The counter returns to zero after it has sat at the period value for one tick. The pin shows the channel's initial level while the counter is below the duty value. It shows the opposite level from the duty value up to the period value.

Software starts channels by writing ones into a shared set strobe register and stops them through a shared clear strobe register. A read-only register reports which counters are running. Setting the duty value above the period keeps the pin at its initial level, so a channel can be parked cleanly. When the output enable is dropped, a per-channel control bit chooses one of two behaviours. In the abrupt case the pin returns to its initial level at once. In the other case the waveform continues until the counter next wraps. Clock selection and prescaling stay outside the block, and the tick inputs stand in for them.

Address map: word address 0 is the enable-set strobe, 1 the enable-clear strobe and 2 the enable status. Address 3 and any address past the last channel read as zero and ignore writes. Channel n occupies the four words starting at 4*(n+1): control at +0, duty at +1, period at +2 and counter at +3.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0, every counter is stopped and every pin is low.
- R2: A write to address 0 sets each enable bit n whose data bit n is 1; enable bits whose data bit is 0 keep their value.
- R3: A write to address 1 clears each enable bit n whose data bit n is 1 and leaves the others; address 2 reads the enable bits in its low NUM_CH bits.
- R4: A running channel's counter increases by exactly one on every cycle its tick input is high; a stopped channel, or a running one with tick low, keeps its count.
- R5: On a tick while the counter equals the period value, the counter reloads to 0.
- R6: With output enable (control bit 0) set, the pin equals the initial level when count < duty or count > period, and the inverted initial level when duty <= count <= period.
- R7: Control bit 1 set makes the initial level high; clear makes it low.
- R8: While the duty value is greater than the period value, the pin stays at the initial level on every cycle.
- R9: A write to a channel's counter word loads that value, taking priority over a tick in the same cycle.
- R10: With output enable clear and abrupt shutdown (control bit 2) set, the pin shows the initial level from the edge that stores that control word.
- R11: Clearing output enable with abrupt shutdown clear keeps the waveform on the pin until the counter wraps or the channel stops; from then on the pin shows the initial level.
- R12: Register writes and ticks take effect on the clock edge where they are sampled; pin and count reflect them immediately after that edge, and channel words read back the stored control, duty, period and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | NUM_CH | Per-channel count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | CNT_W | Read data (combinational) |
| pin_o | output | NUM_CH | PWM outputs |

## Verification
The hardest situation to reach from the ports is the graceful shutdown. It needs a running channel whose output enable is cleared in the middle of an active phase with abrupt mode off, followed by a wrap. The exact edge on which the pin settles can only be seen if the counter position at the moment of the write is known. A directed sequence sets up a channel with a zero duty value and a short period and drops the enable one tick into the period. It then steps through the wrap edge by edge. A long seeded random run mixes register writes of small compare values with random ticks, so that duty above period, counter loads beyond the period, and enable changes in the same cycle as a wrap all occur often.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

    // control word: bit 2 abrupt shutdown, bit 1 initial level high, bit 0 output enable
    typedef struct packed {
        logic abrupt;
        logic init_hi;
        logic oe;
    } pwm_ctrl_t;

    localparam int unsigned CTRL_W = $bits(pwm_ctrl_t);

    // word offsets inside a channel block
    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_DUTY = 2'd1,
        OFS_PER  = 2'd2,
        OFS_CNT  = 2'd3
    } ch_ofs_e;

    // word offsets inside the global block
    localparam logic [1:0] GLB_SET  = 2'd0;
    localparam logic [1:0] GLB_CLR  = 2'd1;
    localparam logic [1:0] GLB_STAT = 2'd2;

endpackage

// File: rtl/pwm_decode.sv
`timescale 1ns/1ps
module pwm_decode
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    output logic                        set_stb_o,
    output logic                        clr_stb_o,
    output logic [NUM_CH-1:0][3:0]      ch_sel_o
);
    localparam int unsigned BLK_W = ADDR_W - 2;

    logic [BLK_W-1:0] blk;
    logic [1:0]       ofs;

    assign blk = wr_addr_i[ADDR_W-1:2];
    assign ofs = wr_addr_i[1:0];

    assign set_stb_o = wr_en_i && (blk == '0) && (ofs == GLB_SET);
    assign clr_stb_o = wr_en_i && (blk == '0) && (ofs == GLB_CLR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign ch_sel_o[i] = (wr_en_i && (blk == BLK_W'(i + 1))) ? (4'b0001 << ofs) : 4'b0000;
    end

endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [3:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pin_o,
    output pwm_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] duty_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        pwm_ctrl_t        ctrl;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cnt;
        logic             grace;   // waveform still allowed after enable drop
        logic             pin;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     cnt_wr, at_end, wrap, active, drive;

    always_comb begin
        s_d    = s_q;
        cnt_wr = wr_sel_i[OFS_CNT];
        at_end = (s_q.cnt == s_q.period);
        wrap   = run_i & tick_i & at_end & ~cnt_wr;

        if (wr_sel_i[OFS_CTRL]) s_d.ctrl   = pwm_ctrl_t'(wr_data_i[CTRL_W-1:0]);
        if (wr_sel_i[OFS_DUTY]) s_d.duty   = wr_data_i;
        if (wr_sel_i[OFS_PER])  s_d.period = wr_data_i;

        if (cnt_wr) begin
            s_d.cnt = wr_data_i;
        end else if (run_i & tick_i) begin
            s_d.cnt = at_end ? '0 : s_q.cnt + 1'b1;
        end

        s_d.grace = s_d.ctrl.oe | (s_q.grace & ~wrap & run_i);
        active    = (s_d.cnt >= s_d.duty) && (s_d.cnt <= s_d.period);
        drive     = s_d.ctrl.oe | (s_d.grace & ~s_d.ctrl.abrupt);
        s_d.pin   = s_d.ctrl.init_hi ^ (drive & active);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pin_o    = s_q.pin;
    assign ctrl_o   = s_q.ctrl;
    assign duty_o   = s_q.duty;
    assign period_o = s_q.period;
    assign cnt_o    = s_q.cnt;

endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,   // must not exceed CNT_W
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 6    // 2**ADDR_W >= 4*(NUM_CH+1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic [NUM_CH-1:0] pin_o
);
    localparam int unsigned BLK_W = ADDR_W - 2;

    logic                         set_stb, clr_stb;
    logic [NUM_CH-1:0][3:0]       ch_sel;
    logic [NUM_CH-1:0]            en_d, en_q;
    logic [NUM_CH-1:0]            set_mask, clr_mask;
    pwm_ctrl_t [NUM_CH-1:0]       ctrl_v;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_v, per_v, cnt_v;
    logic [BLK_W-1:0]             rd_blk;
    logic [1:0]                   rd_ofs;

    pwm_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) dec_i (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .set_stb_o (set_stb),
        .clr_stb_o (clr_stb),
        .ch_sel_o  (ch_sel)
    );

    // shared run register
    always_comb begin
        set_mask = set_stb ? wr_data_i[NUM_CH-1:0] : '0;
        clr_mask = clr_stb ? wr_data_i[NUM_CH-1:0] : '0;
        en_d     = (en_q | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_chan #(
            .CNT_W (CNT_W)
        ) chan_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .tick_i    (tick_i[i]),
            .run_i     (en_q[i]),
            .wr_sel_i  (ch_sel[i]),
            .wr_data_i (wr_data_i),
            .pin_o     (pin_o[i]),
            .ctrl_o    (ctrl_v[i]),
            .duty_o    (duty_v[i]),
            .period_o  (per_v[i]),
            .cnt_o     (cnt_v[i])
        );
    end

    // read mux
    assign rd_blk = rd_addr_i[ADDR_W-1:2];
    assign rd_ofs = rd_addr_i[1:0];

    always_comb begin
        rd_data_o = '0;
        if ((rd_blk == '0) && (rd_ofs == GLB_STAT)) begin
            rd_data_o = CNT_W'(en_q);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_blk == BLK_W'(i + 1)) begin
                case (ch_ofs_e'(rd_ofs))
                    OFS_CTRL: rd_data_o = CNT_W'(ctrl_v[i]);
                    OFS_DUTY: rd_data_o = duty_v[i];
                    OFS_PER:  rd_data_o = per_v[i];
                    default:  rd_data_o = cnt_v[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 6
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic [NUM_CH-1:0]            tick_i,
    input logic                         wr_en_i,
    input logic [ADDR_W-1:0]            wr_addr_i,
    input logic [NUM_CH-1:0]            wr_bits_i,
    input logic [NUM_CH-1:0]            en_q,
    input pwm_ctrl_t [NUM_CH-1:0]       ctrl_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] duty_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] per_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
    input logic [NUM_CH-1:0]            pin_o
);
    // R2: set strobe turns on every selected channel
    a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_W'(0)) |=> ((en_q & $past(wr_bits_i)) == $past(wr_bits_i)));

    // R3: clear strobe turns off every selected channel
    a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_W'(1)) |=> ((en_q & $past(wr_bits_i)) == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: no write and no running tick leaves the count alone
        a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!wr_en_i && !(en_q[i] && tick_i[i])) |=> $stable(cnt_v[i]));

        // R5: tick at the period value reloads zero
        a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!wr_en_i && en_q[i] && tick_i[i] && cnt_v[i] == per_v[i]) |=> (cnt_v[i] == '0));

        // R8: duty beyond period parks the pin
        a_r8_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (duty_v[i] > per_v[i]) |-> (pin_o[i] == ctrl_v[i].init_hi));

        // R10: abrupt shutdown with output disabled shows the initial level
        a_r10_abrupt: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!ctrl_v[i].oe && ctrl_v[i].abrupt) |-> (pin_o[i] == ctrl_v[i].init_hi));
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bits_i (wr_data_i[NUM_CH-1:0]),
    .en_q      (en_q),
    .ctrl_v    (ctrl_v),
    .duty_v    (duty_v),
    .per_v     (per_v),
    .cnt_v     (cnt_v),
    .pin_o     (pin_o)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tick = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  pin;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_bank dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .pin_o     (pin)
    );

    // reference model state
    logic [2:0]  m_ctrl [8];
    logic [15:0] m_duty [8];
    logic [15:0] m_per  [8];
    logic [15:0] m_cnt  [8];
    logic        m_grace[8];
    logic        m_pin  [8];
    logic [7:0]  m_en;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] m_pins();
        logic [7:0] p;
        for (int c = 0; c < 8; c++) p[c] = m_pin[c];
        return p;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [5:0] a);
        int idx;
        if (a[5:2] == 4'd0) return (a[1:0] == 2'd2) ? {8'd0, m_en} : 16'd0;
        if (a[5:2] > 4'd8) return 16'd0;
        idx = int'(a[5:2]) - 1;
        case (a[1:0])
            2'd0:    return {13'd0, m_ctrl[idx]};
            2'd1:    return m_duty[idx];
            2'd2:    return m_per[idx];
            default: return m_cnt[idx];
        endcase
    endfunction

    // one clock: drive at negedge, advance model, compare after the edge
    task automatic cyc(input logic we, input logic [5:0] a, input logic [15:0] d, input logic [7:0] tk);
        logic [2:0]  n_ctrl [8];
        logic [15:0] n_duty [8];
        logic [15:0] n_per  [8];
        logic [15:0] n_cnt  [8];
        logic        n_grace[8];
        logic        n_pin  [8];
        logic [7:0]  n_en;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; tick = tk;
        for (int c = 0; c < 8; c++) begin
            logic sel, wrp, act, drv;
            sel = we && (a[5:2] == 4'(c + 1));
            n_ctrl[c] = (sel && a[1:0] == 2'd0) ? d[2:0] : m_ctrl[c];
            n_duty[c] = (sel && a[1:0] == 2'd1) ? d : m_duty[c];
            n_per[c]  = (sel && a[1:0] == 2'd2) ? d : m_per[c];
            wrp = m_en[c] && tk[c] && (m_cnt[c] == m_per[c]) && !(sel && a[1:0] == 2'd3);
            if (sel && a[1:0] == 2'd3)   n_cnt[c] = d;
            else if (m_en[c] && tk[c])   n_cnt[c] = wrp ? 16'd0 : m_cnt[c] + 16'd1;
            else                         n_cnt[c] = m_cnt[c];
            n_grace[c] = n_ctrl[c][0] || (m_grace[c] && !wrp && m_en[c]);
            act = (n_cnt[c] >= n_duty[c]) && (n_cnt[c] <= n_per[c]);
            drv = n_ctrl[c][0] || (n_grace[c] && !n_ctrl[c][2]);
            n_pin[c] = drv ? (n_ctrl[c][1] ^ act) : n_ctrl[c][1];
        end
        n_en = m_en;
        if (we && a == 6'd0) n_en = m_en | d[7:0];
        if (we && a == 6'd1) n_en = m_en & ~d[7:0];
        @(posedge clk);
        #1;
        for (int c = 0; c < 8; c++) begin
            m_ctrl[c] = n_ctrl[c]; m_duty[c] = n_duty[c]; m_per[c] = n_per[c];
            m_cnt[c] = n_cnt[c]; m_grace[c] = n_grace[c]; m_pin[c] = n_pin[c];
        end
        m_en = n_en;
        chk("R6 pins vs model", {8'd0, pin}, {8'd0, m_pins()});
        chk("R12 readback vs model", rd_data, exp_rd(rd_addr));
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 8'h00);
    endtask

    task automatic tk(input logic [7:0] m);
        cyc(1'b0, 6'd0, 16'd0, m);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [6:0]  exp_pin_seq;
        logic [15:0] exp_cnt_seq [7];
        void'($urandom(32'd20250611));
        m_en = '0;
        for (int c = 0; c < 8; c++) begin
            m_ctrl[c] = '0; m_duty[c] = '0; m_per[c] = '0;
            m_cnt[c] = '0; m_grace[c] = 1'b0; m_pin[c] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 pins low", {8'd0, pin}, 16'd0);
        rd(6'd2, v);  chk("R1 status", v, 16'd0);
        rd(6'd4, v);  chk("R1 ctrl0", v, 16'd0);
        rd(6'd7, v);  chk("R1 count0", v, 16'd0);

        // R2 set strobe, R3 clear strobe
        wr(6'd0, 16'h0005);
        rd(6'd2, v);  chk("R2 status after set 05", v, 16'h0005);
        wr(6'd0, 16'h0002);
        rd(6'd2, v);  chk("R2 zero bits kept", v, 16'h0007);
        wr(6'd1, 16'h0004);
        rd(6'd2, v);  chk("R3 clear bit2", v, 16'h0003);
        wr(6'd1, 16'h0003);
        rd(6'd2, v);  chk("R3 clear rest", v, 16'h0000);

        // R9 counter load, R4 counting
        wr(6'd6, 16'd100);
        wr(6'd7, 16'd7);
        rd(6'd7, v);  chk("R9 count load", v, 16'd7);
        wr(6'd0, 16'h0001);
        tk(8'h01); tk(8'h01); tk(8'h01);
        tk(8'h00); tk(8'h00);
        rd(6'd7, v);  chk("R4 three ticks", v, 16'd10);
        cyc(1'b1, 6'd7, 16'h0020, 8'h01);
        rd(6'd7, v);  chk("R9 write beats tick", v, 16'h0020);
        wr(6'd1, 16'h0001);
        tk(8'h01); tk(8'h01);
        rd(6'd7, v);  chk("R4 stopped holds", v, 16'h0020);

        // R5 / R6 waveform on channel 1: duty 2, period 4, low initial
        wr(6'd9, 16'd2);
        wr(6'd10, 16'd4);
        wr(6'd11, 16'd0);
        wr(6'd8, 16'd1);
        chk("R6 below duty", {15'd0, pin[1]}, 16'd0);
        wr(6'd0, 16'h0002);
        exp_pin_seq = 7'b1001110;   // bit k = pin after tick k
        exp_cnt_seq = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd0, 16'd1, 16'd2};
        for (int k = 0; k < 7; k++) begin
            tk(8'h02);
            chk("R6 duty/period shape", {15'd0, pin[1]}, {15'd0, exp_pin_seq[k]});
            rd(6'd11, v);
            chk("R5 count sequence with wrap", v, exp_cnt_seq[k]);
        end

        // R10 abrupt shutdown while active
        wr(6'd8, 16'd4);
        chk("R10 abrupt to initial", {15'd0, pin[1]}, 16'd0);
        tk(8'h02);
        chk("R10 stays initial", {15'd0, pin[1]}, 16'd0);

        // R7 initial level high: count 3 now
        wr(6'd8, 16'd3);
        chk("R7 active phase inverted", {15'd0, pin[1]}, 16'd0);
        tk(8'h02); tk(8'h02);
        chk("R7 initial level high", {15'd0, pin[1]}, 16'd1);
        wr(6'd1, 16'h0002);

        // R8 duty above period on channel 2
        wr(6'd13, 16'd9);
        wr(6'd14, 16'd5);
        wr(6'd15, 16'd0);
        wr(6'd12, 16'd1);
        wr(6'd0, 16'h0004);
        for (int k = 0; k < 12; k++) begin
            tk(8'h04);
            chk("R8 parked low", {15'd0, pin[2]}, 16'd0);
        end
        wr(6'd12, 16'd3);
        for (int k = 0; k < 6; k++) begin
            tk(8'h04);
            chk("R8 parked high", {15'd0, pin[2]}, 16'd1);
        end
        wr(6'd1, 16'h0004);

        // R11 graceful shutdown on channel 3: duty 0, period 3
        wr(6'd17, 16'd0);
        wr(6'd18, 16'd3);
        wr(6'd19, 16'd0);
        wr(6'd16, 16'd1);
        chk("R11 active at count 0", {15'd0, pin[3]}, 16'd1);
        wr(6'd0, 16'h0008);
        tk(8'h08);
        wr(6'd16, 16'd0);
        chk("R11 waveform kept after disable", {15'd0, pin[3]}, 16'd1);
        tk(8'h08);
        tk(8'h08);
        chk("R11 kept at period", {15'd0, pin[3]}, 16'd1);
        tk(8'h08);
        chk("R11 initial after wrap", {15'd0, pin[3]}, 16'd0);
        tk(8'h08);
        chk("R11 stays initial", {15'd0, pin[3]}, 16'd0);
        wr(6'd1, 16'h0008);

        // seeded random traffic checked against the model (R6, R12)
        for (int n = 0; n < 4000; n++) begin
            logic        we;
            logic [1:0]  o;
            logic [5:0]  a;
            logic [15:0] d;
            int          c;
            rd_addr = 6'($urandom_range(0, 39));
            we = ($urandom_range(0, 3) == 0);
            c  = $urandom_range(0, 7);
            o  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 4) == 0) a = {4'd0, o};
            else                           a = {4'(c + 1), o};
            case (o)
                2'd1, 2'd2: d = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom_range(0, 9));
                2'd3:       d = 16'($urandom_range(0, 12));
                default:    d = 16'($urandom);
            endcase
            cyc(we, a, d, 8'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule